// File: doc/BRIEF.md
# PWM-Output Automatic Gain Control Loop

This block closes a gain-control loop around an external variable-gain amplifier. It takes signed samples from a 9-bit converter and averages their absolute values over fixed blocks of 256 samples. At the end of each block it compares the average with a software-set reference level. The signed difference, scaled down by a programmable shift, is added to a 10-bit gain command that saturates at both ends.

The command leaves the chip on a single pin as a pulse-width-modulated waveform with a 1024-clock period. A single resistor-capacitor low-pass network outside the chip turns this pin into the analog gain voltage. A new command and a new output polarity take effect only at a period boundary, so the waveform never carries a runt pulse. The polarity can be inverted for amplifiers whose gain falls as the control voltage rises.

Software writes two configuration words through a simple write port. One holds the reference level. The other holds the loop shift and the polarity bit.

Top module: `agc_pwm_loop`

## Requirements
- R1: Each valid sample is read as a 9-bit two's-complement value, and its magnitude is its absolute value, so -256 counts as 256.
- R2: The magnitude estimate is floor(sum of the magnitudes of 256 consecutive valid samples / 256). Cycles with `smp_valid` low are skipped. `mag_est` and a one-cycle `mag_strobe` appear on the clock edge that takes in the 256th sample, and `mag_est` holds until the next block ends.
- R3: On the clock edge after `mag_strobe` is high, `gain_cmd` becomes `gain_cmd + ((ref - mag_est) >>> k)`, an arithmetic (floor) right shift. At no other time does `gain_cmd` change.
- R4: The updated command is clamped to the range 0 to 1023.
- R5: When `cfg_we` is high, `cfg_sel`=0 writes the reference level from `cfg_wdata[8:0]`. `cfg_sel`=1 writes the shift k from `cfg_wdata[2:0]` and the invert bit from `cfg_wdata[3]`. When `cfg_we` is low the configuration is unchanged.
- R6: The PWM period is 1024 clocks. A free-running 10-bit counter starts at 0 after reset, and the raw output is high while the counter is below the latched duty value.
- R7: The latched duty value and the latched polarity are loaded from `gain_cmd` and the invert bit only on the edge where the counter wraps from 1023 to 0.
- R8: When the latched polarity is 1, `pwm_out` is the complement of the raw output.
- R9: A synchronous reset sets the command and the latched duty to 512, the reference to 128, k to 0 and the invert bit to 0, and it clears the estimator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 9 | Signed converter sample |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | Configuration word select |
| cfg_wdata | input | 9 | Configuration write data |
| pwm_out | output | 1 | PWM gain-control pin |
| gain_cmd | output | 10 | Current gain command |
| mag_est | output | 9 | Latest magnitude estimate |
| mag_strobe | output | 1 | One-cycle pulse when a new estimate is ready |

## Verification
The assertions check several rules on every cycle:
- the command changes only right after a strobe;
- the command holds at either rail when the error pushes it outward;
- the counter wraps;
- the duty value and polarity stay frozen away from the wrap;
- the configuration holds without a write.

Other behaviours can be shown only by the bench's scenarios:
- the exact block averaging, including the -256 sample and skipped invalid cycles;
- the floor rounding of negative shifted errors;
- the high-time count over a full period in each polarity.

// File: rtl/agc_pkg.sv
package agc_pkg;

  localparam int unsigned SHIFT_W = 3;

  typedef struct packed {
    logic               invert;
    logic [SHIFT_W-1:0] shift;
  } agc_ctrl_t;

  // Clamp an integer into [0, hi]
  function automatic int clamp_range(input int v, input int hi);
    if (v < 0)       return 0;
    else if (v > hi) return hi;
    else             return v;
  endfunction

endpackage

// File: rtl/agc_mag_est.sv
module agc_mag_est #(
  parameter int unsigned SMP_W    = 9,
  parameter int unsigned BLK_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_data,
  output logic [SMP_W-1:0] est,
  output logic             est_stb
);
  localparam int unsigned ACC_W = SMP_W + BLK_LOG2;

  logic [BLK_LOG2-1:0] cnt_q;
  logic [ACC_W-1:0]    acc_q;
  logic [SMP_W-1:0]    mag;
  logic [ACC_W-1:0]    total;
  logic                blk_last;

  function automatic logic [SMP_W-1:0] abs_val(input logic [SMP_W-1:0] x);
    return x[SMP_W-1] ? (~x + 1'b1) : x;
  endfunction

  assign mag      = abs_val(in_data);
  assign total    = acc_q + ACC_W'(mag);
  assign blk_last = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      est     <= '0;
      est_stb <= 1'b0;
    end else begin
      est_stb <= 1'b0;
      if (in_valid) begin
        cnt_q <= cnt_q + 1'b1;
        if (blk_last) begin
          acc_q   <= '0;
          est     <= total[ACC_W-1:BLK_LOG2];
          est_stb <= 1'b1;
        end else begin
          acc_q <= total;
        end
      end
    end
  end

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    est_stb |=> !est_stb);
  assert_est_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !est_stb |-> $stable(est));
  assert_est_bound_R1: assert property (@(posedge clk) disable iff (rst)
    est <= SMP_W'(1 << (SMP_W - 1)));

endmodule

// File: rtl/agc_loop_filter.sv
module agc_loop_filter
  import agc_pkg::*;
#(
  parameter int unsigned SMP_W = 9,
  parameter int unsigned CMD_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SMP_W-1:0]   est,
  input  logic               est_stb,
  input  logic [SMP_W-1:0]   ref_lvl,
  input  logic [SHIFT_W-1:0] shift,
  output logic [CMD_W-1:0]   cmd
);
  localparam int unsigned E_W = SMP_W + 1;
  localparam int unsigned S_W = ((CMD_W > E_W) ? CMD_W : E_W) + 2;
  localparam logic [CMD_W-1:0] CMD_MAX = '1;
  localparam logic [CMD_W-1:0] CMD_MID = CMD_W'(1 << (CMD_W - 1));

  logic signed [E_W-1:0] err;
  logic signed [E_W-1:0] step;
  logic signed [S_W-1:0] sum;
  logic                  sat_lo;
  logic                  sat_hi;
  logic [CMD_W-1:0]      cmd_next;

  assign err    = $signed({1'b0, ref_lvl}) - $signed({1'b0, est});
  assign step   = err >>> shift;
  assign sum    = $signed({{(S_W-CMD_W){1'b0}}, cmd}) + $signed({{(S_W-E_W){step[E_W-1]}}, step});
  assign sat_lo = sum[S_W-1];
  assign sat_hi = !sat_lo && (sum > $signed({{(S_W-CMD_W){1'b0}}, CMD_MAX}));

  always_comb begin
    if (sat_lo)      cmd_next = '0;
    else if (sat_hi) cmd_next = CMD_MAX;
    else             cmd_next = sum[CMD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          cmd <= CMD_MID;
    else if (est_stb) cmd <= cmd_next;
  end

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !est_stb |=> $stable(cmd));
  assert_sat_hi_R4: assert property (@(posedge clk) disable iff (rst)
    (est_stb && cmd == CMD_MAX && ref_lvl >= est) |=> cmd == CMD_MAX);
  assert_sat_lo_R4: assert property (@(posedge clk) disable iff (rst)
    (est_stb && cmd == '0 && ref_lvl <= est) |=> cmd == '0);

endmodule

// File: rtl/agc_pwm_gen.sv
module agc_pwm_gen #(
  parameter int unsigned CMD_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] duty_in,
  input  logic             invert_in,
  output logic             pwm
);
  localparam logic [CMD_W-1:0] CNT_MAX = '1;
  localparam logic [CMD_W-1:0] CMD_MID = CMD_W'(1 << (CMD_W - 1));

  logic [CMD_W-1:0] cnt_q;
  logic [CMD_W-1:0] duty_q;
  logic             pol_q;
  logic             wrap;
  logic             raw;

  assign wrap = (cnt_q == CNT_MAX);
  assign raw  = (cnt_q < duty_q);
  assign pwm  = raw ^ pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      duty_q <= CMD_MID;
      pol_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap) begin
        duty_q <= duty_in;
        pol_q  <= invert_in;
      end
    end
  end

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt_q == '0);
  assert_duty_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(duty_q) && $stable(pol_q)));

endmodule

// File: rtl/agc_pwm_loop.sv
module agc_pwm_loop
  import agc_pkg::*;
#(
  parameter int unsigned SMP_W    = 9,
  parameter int unsigned BLK_LOG2 = 8,
  parameter int unsigned CMD_W    = 10,
  parameter int unsigned REF_INIT = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [SMP_W-1:0] cfg_wdata,
  output logic             pwm_out,
  output logic [CMD_W-1:0] gain_cmd,
  output logic [SMP_W-1:0] mag_est,
  output logic             mag_strobe
);
  logic [SMP_W-1:0] ref_q;
  agc_ctrl_t        ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= SMP_W'(REF_INIT);
      ctrl_q <= '0;
    end else if (cfg_we) begin
      if (!cfg_sel) ref_q <= cfg_wdata;
      else          ctrl_q <= agc_ctrl_t'(cfg_wdata[SHIFT_W:0]);
    end
  end

  agc_mag_est #(.SMP_W(SMP_W), .BLK_LOG2(BLK_LOG2)) u_mag (
    .clk(clk), .rst(rst), .in_valid(smp_valid), .in_data(smp_data),
    .est(mag_est), .est_stb(mag_strobe)
  );

  agc_loop_filter #(.SMP_W(SMP_W), .CMD_W(CMD_W)) u_filt (
    .clk(clk), .rst(rst), .est(mag_est), .est_stb(mag_strobe),
    .ref_lvl(ref_q), .shift(ctrl_q.shift), .cmd(gain_cmd)
  );

  agc_pwm_gen #(.CMD_W(CMD_W)) u_pwm (
    .clk(clk), .rst(rst), .duty_in(gain_cmd), .invert_in(ctrl_q.invert),
    .pwm(pwm_out)
  );

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(ref_q) && $stable(ctrl_q)));

endmodule

// File: tb/agc_pwm_loop_tb.sv
module agc_pwm_loop_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic [8:0] smp_data = '0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [8:0] cfg_wdata = '0;
  logic       pwm_out;
  logic [9:0] gain_cmd;
  logic [8:0] mag_est;
  logic       mag_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  agc_pwm_loop dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pwm_out(pwm_out), .gain_cmd(gain_cmd), .mag_est(mag_est),
    .mag_strobe(mag_strobe)
  );

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int lim(input int v);
    return (v < 0) ? 0 : ((v > 1023) ? 1023 : v);
  endfunction

  function automatic int s9(input logic [8:0] x);
    return x[8] ? int'(x) - 512 : int'(x);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_q[$];
  int m_est, m_cmd, m_pcnt, m_duty, m_ref, m_k;
  bit m_stb, m_pola, m_inv;

  always @(posedge clk) begin
    int n_cmd, n_est, n_duty, s;
    bit n_stb, n_pola;
    if (rst) begin
      m_q.delete();
      m_est = 0; m_stb = 0; m_cmd = 512; m_pcnt = 0; m_duty = 512;
      m_pola = 0; m_ref = 128; m_k = 0; m_inv = 0;
    end else begin
      n_cmd = m_cmd;
      if (m_stb) n_cmd = lim(m_cmd + ((m_ref - m_est) >>> m_k));
      n_duty = m_duty; n_pola = m_pola;
      if (m_pcnt == 1023) begin n_duty = m_cmd; n_pola = m_inv; end
      n_stb = 0; n_est = m_est;
      if (smp_valid) begin
        m_q.push_back(iabs(s9(smp_data)));
        if (m_q.size() == 256) begin
          s = 0;
          foreach (m_q[i]) s += m_q[i];
          n_est = s / 256; n_stb = 1;
          m_q.delete();
        end
      end
      if (cfg_we) begin
        if (!cfg_sel) m_ref = int'(cfg_wdata);
        else begin m_k = int'(cfg_wdata[2:0]); m_inv = cfg_wdata[3]; end
      end
      m_cmd = n_cmd; m_est = n_est; m_stb = n_stb;
      m_duty = n_duty; m_pola = n_pola; m_pcnt = (m_pcnt + 1) % 1024;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(gain_cmd == 10'(m_cmd), "R3 R4 model gain_cmd", int'(gain_cmd), m_cmd);
      check(mag_est == 9'(m_est), "R1 R2 model mag_est", int'(mag_est), m_est);
      check(mag_strobe == m_stb, "R2 model mag_strobe", int'(mag_strobe), int'(m_stb));
      check(pwm_out == ((m_pcnt < m_duty) ^ m_pola), "R6 R7 R8 model pwm_out",
            int'(pwm_out), int'((m_pcnt < m_duty) ^ m_pola));
    end
  end

  // Bench's own view of the configuration
  int e_ref = 128, e_k = 0;
  bit e_inv = 0;

  task automatic cfg_write(input bit sel, input int data, input bit we);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = 9'(data);
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = 9'h155;
    if (we) begin
      if (!sel) e_ref = data;
      else begin e_k = data & 7; e_inv = data[3]; end
    end
  endtask

  task automatic run_block(input int a, input int b, input int gap);
    int prev, est_e, cmd_e;
    prev = int'(gain_cmd);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data = 9'((i % 2) ? b : a);
      for (int g = 0; g < gap && i < 255; g++) begin
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data = 9'h0FF;
      end
    end
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    est_e = (iabs(a) * 128 + iabs(b) * 128) / 256;
    cmd_e = lim(prev + ((e_ref - est_e) >>> e_k));
    check(mag_est == 9'(est_e), "R1 R2 block estimate", int'(mag_est), est_e);
    check(gain_cmd == 10'(cmd_e), "R3 R4 block command", int'(gain_cmd), cmd_e);
  endtask

  task automatic count_high(input string req);
    int hi, exp;
    repeat (2100) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    exp = e_inv ? 1024 - int'(gain_cmd) : int'(gain_cmd);
    check(hi == exp, req, hi, exp);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(gain_cmd == 10'd512, "R9 reset command", int'(gain_cmd), 512);
    check(mag_strobe == 1'b0, "R9 reset strobe", int'(mag_strobe), 0);
    check(pwm_out == 1'b1, "R9 reset pwm level", int'(pwm_out), 1);

    run_block(100, 100, 0);            // R3: 512 + 28 = 540
    run_block(-256, 0, 1);             // R1 R2: est 128, gaps skipped
    cfg_write(1'b0, 300, 1'b0);        // R5: ignored write
    run_block(200, 200, 0);            // R5: ref still 128 -> 468
    cfg_write(1'b1, 3, 1'b1);          // k = 3
    run_block(200, -200, 0);           // R3: -72 >>> 3 = -9 -> 459
    run_block(129, 129, 0);            // R3: -1 >>> 3 = -1 -> 458
    count_high("R6 high time");
    cfg_write(1'b1, 8, 1'b1);          // invert, k = 0
    count_high("R8 inverted high time");
    cfg_write(1'b0, 0, 1'b1);
    run_block(-256, -256, 0);          // 202
    run_block(-256, -256, 0);          // R4 low clamp -> 0
    run_block(-256, -256, 0);          // R4 stays 0
    cfg_write(1'b0, 511, 1'b1);
    run_block(0, 0, 0);                // 511
    run_block(0, 0, 0);                // 1022
    run_block(0, 0, 2);                // R4 high clamp -> 1023
    count_high("R8 inverted full command");
    cfg_write(1'b1, 0, 1'b1);
    count_high("R6 R7 full command");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule